// File: doc/BRIEF.md
# Compare-Match General Purpose Timer

This block is a memory-mapped up-counting timer with a programmable prescaler, three compare channels and a single level interrupt. Software reaches it over a simple synchronous register port: a word index, a write strobe, write data, and read data that shows the addressed register combinationally in the same cycle. Two single-cycle tick enables come in from outside: a fast peripheral tick and a slow 32 kHz tick. A coded field in the control register picks one of them, or none. The counter advances once every `prescaler + 1` selected ticks.

In free-run mode the counter climbs to all ones and wraps to zero, and the wrap raises a rollover flag. In restart mode, compare channel 1 sets the period: the counter goes back to zero on the tick after it reaches that compare value. Compare matches and the rollover land in a write-one-to-clear status register. The interrupt output is the OR of the status bits masked by their enables, gated by the timer enable. Setting a control bit starts a software reset. It clears the timing state but keeps the clock-source and mode selections that were written with it. Input capture is not built; its two registers read as zero.

Top module: `cmt_timer`

## Requirements
- R1: The word index picks the register: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture (always read 0), 9 counter. Any other index reads 0. Narrow registers read zero-extended.
- R2: A control write stores the data with bits 2, 4 and 10 to 14 forced to 0. Bit 15 (software reset) is never stored, so it reads back as 0.
- R3: Control bits 8:6 select the count source. Codes 001 and 010 take the fast tick, code 100 takes the slow tick, and every other code stops the counter.
- R4: The prescaler keeps only write data bits 11:0. With the enable (control bit 0) set, the counter steps once every (prescaler + 1) selected ticks. Counting starts afresh each time the enable goes from 0 to 1.
- R5: With control bit 9 set (free-run), the counter wraps from all ones to 0. The tick that makes that wrap sets status bit 5.
- R6: With control bit 9 clear (restart), the counter goes to 0 on the step after it equals compare 1. Writing compare 1 in this mode clears the counter at once.
- R7: A step that moves the counter onto the value of compare n (n = 1, 2, 3) sets status bit n-1.
- R8: Writing status clears each of bits 5:0 that has a 1 in the write data and leaves the others alone. A flag set in the same cycle as it is cleared stays set.
- R9: The interrupt output is high exactly when control bit 0 is set and some status bit is 1 together with the same bit of the interrupt-enable register (6 bits, aligned with status).
- R10: When control bit 0 goes from 0 to 1 with control bit 1 set, the counter restarts from 0. With bit 1 clear, it keeps its held value. While disabled, the counter holds.
- R11: A control write with bit 15 set stores the data with bits 5:0 (and the R2 bits) cleared. It zeroes the prescaler, status, interrupt enable and counter, and sets every compare register to all ones.
- R12: Hardware reset leaves control at 0 and every other register as after a software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_widx | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| tick_fast | input | 1 | Fast peripheral tick enable, one cycle wide |
| tick_slow | input | 1 | Slow 32 kHz tick enable, one cycle wide |
| irq | output | 1 | Level interrupt |

## Verification
Every register, the counter and the status bits update on the rising edge that takes the write or the tick. The effect is on the read data from the next cycle on. The interrupt follows the status and enable registers in that same cycle, with no further delay. The bench drives a write or a tick pattern just after a falling edge. It reads and compares a register and the interrupt one nanosecond later, before the next rising edge, so each sample sees the state committed by the step before. A bench model makes the same one-edge update per step, driven by the requirements, and a set of directed sequences compares against literal values at the prescaler, wrap, restart and set-versus-clear corners.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int BUS_DW  = 32;
    localparam int IDX_W   = 4;
    localparam int ST_W    = 6;
    localparam int NUM_CMP = 3;

    // register word indices
    localparam logic [IDX_W-1:0] RI_CTRL = 4'd0;
    localparam logic [IDX_W-1:0] RI_PSC  = 4'd1;
    localparam logic [IDX_W-1:0] RI_STAT = 4'd2;
    localparam logic [IDX_W-1:0] RI_IEN  = 4'd3;
    localparam logic [IDX_W-1:0] RI_CMP0 = 4'd4;
    localparam logic [IDX_W-1:0] RI_CAP0 = 4'd7;
    localparam logic [IDX_W-1:0] RI_CAP1 = 4'd8;
    localparam logic [IDX_W-1:0] RI_CNT  = 4'd9;

    // control bit positions
    localparam int CB_EN     = 0;
    localparam int CB_ENMODE = 1;
    localparam int CB_SRC_LO = 6;
    localparam int CB_FREE   = 9;
    localparam int CB_SWR    = 15;

    localparam logic [BUS_DW-1:0] CTL_ZERO_MASK = 32'h0000_7C14;
    localparam logic [BUS_DW-1:0] CTL_SRST_MASK = 32'h0000_803F;

    localparam int SB_ROLL = 5;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'b000,
        SRC_FAST1 = 3'b001,
        SRC_FAST2 = 3'b010,
        SRC_SLOW  = 3'b100
    } src_code_e;

    // decoded effects of one bus write
    typedef struct packed {
        logic srst;
        logic en_rise;
        logic mode_rst;
        logic cmp0_restart;
    } wr_evt_t;

    function automatic logic pick_tick(logic [2:0] code, logic tf, logic ts);
        logic t;
        case (code)
            SRC_FAST1, SRC_FAST2: t = tf;
            SRC_SLOW:             t = ts;
            default:              t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/cmt_tick_div.sv
module cmt_tick_div
    import cmt_pkg::*;
#(
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [2:0]       src_code,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic [PSC_W-1:0] psc,
    output logic             adv
);

    logic [PSC_W-1:0] div_q;
    logic             tick;

    assign tick = pick_tick(src_code, tick_fast, tick_slow);
    assign adv  = run && tick && (div_q >= psc);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (run && tick) begin
            div_q <= adv ? '0 : div_q + 1'b1;
        end
    end

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int CNT_W   = 32,
    parameter int NUM_CMP = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          adv,
    input  logic                          restart_mode,
    input  logic                          clear,
    input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]              cnt,
    output logic [NUM_CMP-1:0]            match,
    output logic                          wrap
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;

    assign nxt  = (restart_mode && cnt_q == cmp[0]) ? '0 : cnt_q + 1'b1;
    assign wrap = adv && (cnt_q == {CNT_W{1'b1}});
    assign cnt  = cnt_q;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_match
        assign match[i] = adv && (nxt == cmp[i]);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= nxt;
        end
    end

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  bus_widx,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              irq
);

    logic [BUS_DW-1:0]            ctrl_q;
    logic [PSC_W-1:0]             psc_q;
    logic [ST_W-1:0]              st_q;
    logic [ST_W-1:0]              ien_q;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;

    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_CMP-1:0] match;
    logic               wrap;
    logic               adv;
    wr_evt_t            ev;
    logic               wr_ctrl;
    logic [ST_W-1:0]    set_vec;
    logic [ST_W-1:0]    w1c;

    // write decode
    assign wr_ctrl         = bus_we && (bus_widx == RI_CTRL);
    assign ev.srst         = wr_ctrl && bus_wdata[CB_SWR];
    assign ev.en_rise      = wr_ctrl && !bus_wdata[CB_SWR] && !ctrl_q[CB_EN] && bus_wdata[CB_EN];
    assign ev.mode_rst     = ev.en_rise && bus_wdata[CB_ENMODE];
    assign ev.cmp0_restart = bus_we && (bus_widx == RI_CMP0) && !ctrl_q[CB_FREE];

    cmt_tick_div #(.PSC_W(PSC_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q[CB_EN]),
        .clr       (ev.srst || ev.en_rise),
        .src_code  (ctrl_q[CB_SRC_LO +: 3]),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .psc       (psc_q),
        .adv       (adv)
    );

    cmt_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .adv          (adv),
        .restart_mode (!ctrl_q[CB_FREE]),
        .clear        (ev.srst || ev.mode_rst || ev.cmp0_restart),
        .cmp          (cmp_q),
        .cnt          (cnt_q),
        .match        (match),
        .wrap         (wrap)
    );

    always_comb begin
        set_vec                = '0;
        set_vec[NUM_CMP-1:0]   = match;
        set_vec[SB_ROLL]       = wrap;
        w1c = (bus_we && bus_widx == RI_STAT) ? bus_wdata[ST_W-1:0] : '0;
    end

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            psc_q  <= '0;
            st_q   <= '0;
            ien_q  <= '0;
            cmp_q  <= '1;
        end else if (ev.srst) begin
            ctrl_q <= bus_wdata & ~CTL_ZERO_MASK & ~CTL_SRST_MASK;
            psc_q  <= '0;
            st_q   <= '0;
            ien_q  <= '0;
            cmp_q  <= '1;
        end else begin
            st_q <= (st_q & ~w1c) | set_vec;
            if (bus_we) begin
                case (bus_widx)
                    RI_CTRL: ctrl_q <= bus_wdata & ~CTL_ZERO_MASK;
                    RI_PSC:  psc_q  <= bus_wdata[PSC_W-1:0];
                    RI_IEN:  ien_q  <= bus_wdata[ST_W-1:0];
                    default: ;
                endcase
                for (int i = 0; i < NUM_CMP; i++) begin
                    if (bus_widx == IDX_W'(RI_CMP0 + i)) begin
                        cmp_q[i] <= bus_wdata[CNT_W-1:0];
                    end
                end
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_widx)
            RI_CTRL: bus_rdata = ctrl_q;
            RI_PSC:  bus_rdata = BUS_DW'(psc_q);
            RI_STAT: bus_rdata = BUS_DW'(st_q);
            RI_IEN:  bus_rdata = BUS_DW'(ien_q);
            RI_CAP0, RI_CAP1: bus_rdata = '0;
            RI_CNT:  bus_rdata = BUS_DW'(cnt_q);
            default: bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CMP; i++) begin
            if (bus_widx == IDX_W'(RI_CMP0 + i)) begin
                bus_rdata = BUS_DW'(cmp_q[i]);
            end
        end
    end

    assign irq = ctrl_q[CB_EN] && (|(st_q & ien_q));

endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [BUS_DW-1:0] ctrl_q,
    input logic [ST_W-1:0]   st_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              adv,
    input logic              irq
);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl_q[CB_EN]); // R9

    AST_SWR_NOT_KEPT: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[CB_SWR]); // R2

    AST_STEP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        adv |-> ctrl_q[CB_EN]); // R10

    AST_CNT_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(bus_we) && cnt_q != $past(cnt_q)) |-> $past(adv)); // R4

    AST_ROLL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!$past(bus_we) && $past(cnt_q) == {CNT_W{1'b1}} && cnt_q == '0) |-> st_q[SB_ROLL]); // R5

    AST_MATCH_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        (|(st_q[NUM_CMP-1:0] & ~$past(st_q[NUM_CMP-1:0]))) |-> $past(adv)); // R7

endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .bus_we (bus_we),
    .ctrl_q (ctrl_q),
    .st_q   (st_q),
    .cnt_q  (cnt_q),
    .adv    (adv),
    .irq    (irq)
);

// File: tb/cmt_timer_tb.sv
module cmt_timer_tb;
    import cmt_pkg::*;

    localparam int CW = 12;
    localparam logic [CW-1:0] MAXC = {CW{1'b1}};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_widx = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cmt_timer #(.CNT_W(CW), .PSC_W(12)) u_dut (
        .clk(clk), .rst(rst), .bus_widx(bus_widx), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
    );

    // reference model state
    logic [31:0]   m_ctrl;
    logic [11:0]   m_psc;
    logic [5:0]    m_st, m_ien;
    logic [CW-1:0] m_cmp [3];
    logic [CW-1:0] m_cnt;
    int            m_div;

    task automatic model_reset();
        m_ctrl = '0; m_psc = '0; m_st = '0; m_ien = '0; m_cnt = '0; m_div = 0;
        for (int i = 0; i < 3; i++) m_cmp[i] = MAXC;
    endtask

    function automatic logic [31:0] m_read(logic [3:0] idx);
        case (idx)
            4'd0: return m_ctrl;
            4'd1: return 32'(m_psc);
            4'd2: return 32'(m_st);
            4'd3: return 32'(m_ien);
            4'd4: return 32'(m_cmp[0]);
            4'd5: return 32'(m_cmp[1]);
            4'd6: return 32'(m_cmp[2]);
            4'd9: return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        return m_ctrl[0] && (|(m_st & m_ien));
    endfunction

    task automatic model_update(logic we, logic [3:0] idx, logic [31:0] d, logic tf, logic ts);
        logic [2:0]    code;
        logic          tk, adv;
        logic [CW-1:0] nxt, cnt_n;
        logic [5:0]    set, w1c;
        int            div_n;
        code = m_ctrl[8:6];
        tk   = (code == 3'b001 || code == 3'b010) ? tf : (code == 3'b100) ? ts : 1'b0;
        adv  = m_ctrl[0] && tk && (m_div >= int'(m_psc));
        nxt  = (!m_ctrl[9] && m_cnt == m_cmp[0]) ? '0 : m_cnt + 1'b1;
        set  = '0;
        if (adv) begin
            for (int i = 0; i < 3; i++) set[i] = (nxt == m_cmp[i]);
            set[5] = (m_cnt == MAXC);
        end
        div_n = m_div;
        if (m_ctrl[0] && tk) div_n = adv ? 0 : m_div + 1;
        cnt_n = adv ? nxt : m_cnt;
        w1c   = (we && idx == 4'd2) ? d[5:0] : 6'h0;
        m_st  = (m_st & ~w1c) | set;
        if (we) begin
            case (idx)
                4'd0: begin
                    if (d[15]) begin
                        m_ctrl = d & ~32'h7C14 & ~32'h803F;
                        m_psc = '0; m_st = '0; m_ien = '0; cnt_n = '0; div_n = 0;
                        for (int i = 0; i < 3; i++) m_cmp[i] = MAXC;
                    end else begin
                        if (!m_ctrl[0] && d[0]) begin
                            div_n = 0;
                            if (d[1]) cnt_n = '0;
                        end
                        m_ctrl = d & ~32'h7C14;
                    end
                end
                4'd1: m_psc = d[11:0];
                4'd3: m_ien = d[5:0];
                4'd4: begin
                    if (!m_ctrl[9]) cnt_n = '0;
                    m_cmp[0] = d[CW-1:0];
                end
                4'd5: m_cmp[1] = d[CW-1:0];
                4'd6: m_cmp[2] = d[CW-1:0];
                default: ;
            endcase
        end
        m_cnt = cnt_n;
        m_div = div_n;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive, sample, clock, update model
    task automatic step(logic we, logic [3:0] idx, logic [31:0] d, logic tf, logic ts, string req);
        bus_we = we; bus_widx = idx; bus_wdata = d; tick_fast = tf; tick_slow = ts;
        #1;
        if (!we) chk(req, bus_rdata, m_read(idx));
        chk("R9", {31'b0, irq}, {31'b0, m_irq()});
        @(posedge clk);
        model_update(we, idx, d, tf, ts);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] idx, logic [31:0] d);
        step(1'b1, idx, d, 1'b0, 1'b0, "R1");
    endtask

    task automatic expect_rd(logic [3:0] idx, logic [31:0] exp, string req);
        bus_we = 1'b0; bus_widx = idx; tick_fast = 1'b0; tick_slow = 1'b0;
        #1;
        chk(req, bus_rdata, exp);
        @(posedge clk);
        model_update(1'b0, idx, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    task automatic run(int n, logic tf, logic ts, string req);
        for (int i = 0; i < n; i++) step(1'b0, RI_CNT, 32'h0, tf, ts, req);
    endtask

    function automatic string req_of(logic [3:0] idx);
        case (idx)
            4'd0: return "R2";
            4'd1: return "R4";
            4'd2: return "R7";
            4'd4, 4'd5, 4'd6: return "R6";
            4'd9: return "R5";
            default: return "R1";
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12 reset state, R1 capture reads zero
        expect_rd(RI_CTRL, 32'h0, "R12");
        expect_rd(4'd5, 32'h0000_0FFF, "R12");
        expect_rd(RI_PSC, 32'h0, "R12");
        expect_rd(RI_CAP0, 32'h0, "R1");
        expect_rd(4'd12, 32'h0, "R1");

        // R2 control masking
        wr(RI_CTRL, 32'hFFFF_7FFF);
        expect_rd(RI_CTRL, 32'hFFFF_03EB, "R2");

        // R11 software reset keeps upper fields
        wr(RI_CTRL, 32'h0000_8241);
        expect_rd(RI_CTRL, 32'h0000_0240, "R11");
        expect_rd(RI_CMP0, 32'h0000_0FFF, "R11");

        // R5 free-run wrap with rollover flag
        wr(RI_IEN, 32'h20);
        wr(RI_CTRL, 32'h0000_0243);
        run(4096, 1'b1, 1'b0, "R5");
        expect_rd(RI_STAT, 32'h27, "R5");
        expect_rd(RI_CNT, 32'h0, "R5");
        chk("R9", {31'b0, irq}, 32'h1);

        // R8 write-one-to-clear
        wr(RI_STAT, 32'h01);
        expect_rd(RI_STAT, 32'h26, "R8");
        wr(RI_STAT, 32'h00);
        expect_rd(RI_STAT, 32'h26, "R8");

        // R6 restart mode
        wr(RI_CTRL, 32'h0000_8000);
        wr(RI_CMP0, 32'h5);
        wr(RI_CTRL, 32'h0000_0043);
        run(5, 1'b1, 1'b0, "R6");
        expect_rd(RI_CNT, 32'h5, "R6");
        run(1, 1'b1, 1'b0, "R6");
        expect_rd(RI_CNT, 32'h0, "R6");
        expect_rd(RI_STAT, 32'h01, "R7");
        run(3, 1'b1, 1'b0, "R6");
        wr(RI_CMP0, 32'h9);
        expect_rd(RI_CNT, 32'h0, "R6");

        // R4 prescaler
        wr(RI_CTRL, 32'h0000_8000);
        wr(RI_PSC, 32'hFFFF_F002);
        expect_rd(RI_PSC, 32'h2, "R4");
        wr(RI_CTRL, 32'h0000_0243);
        run(9, 1'b1, 1'b0, "R4");
        expect_rd(RI_CNT, 32'h3, "R4");

        // R3 clock source codes
        wr(RI_CTRL, 32'h0000_8000);
        wr(RI_CTRL, 32'h0000_00C3);
        run(5, 1'b1, 1'b1, "R3");
        expect_rd(RI_CNT, 32'h0, "R3");
        wr(RI_CTRL, 32'h0000_0103);
        run(4, 1'b1, 1'b0, "R3");
        expect_rd(RI_CNT, 32'h0, "R3");
        run(4, 1'b0, 1'b1, "R3");
        expect_rd(RI_CNT, 32'h4, "R3");

        // R10 enable-mode
        wr(RI_CTRL, 32'h0000_0102);
        run(3, 1'b0, 1'b1, "R10");
        expect_rd(RI_CNT, 32'h4, "R10");
        wr(RI_CTRL, 32'h0000_0101);
        expect_rd(RI_CNT, 32'h4, "R10");
        run(2, 1'b0, 1'b1, "R10");
        expect_rd(RI_CNT, 32'h6, "R10");
        wr(RI_CTRL, 32'h0000_0100);
        wr(RI_CTRL, 32'h0000_0103);
        expect_rd(RI_CNT, 32'h0, "R10");

        // R8 set wins over clear
        wr(RI_CTRL, 32'h0000_8000);
        wr(RI_CMP0, 32'h0);
        wr(RI_CTRL, 32'h0000_0041);
        run(2, 1'b1, 1'b0, "R7");
        expect_rd(RI_STAT, 32'h01, "R7");
        step(1'b1, RI_STAT, 32'h1, 1'b1, 1'b0, "R8");
        expect_rd(RI_STAT, 32'h01, "R8");
        step(1'b1, RI_STAT, 32'h1, 1'b0, 1'b0, "R8");
        expect_rd(RI_STAT, 32'h00, "R8");

        // random traffic against the model
        for (int k = 0; k < 6000; k++) begin
            logic [3:0]  idx;
            logic [31:0] d;
            logic        we;
            we  = ($urandom % 8) == 0;
            idx = 4'($urandom % 11);
            d   = $urandom;
            case (idx)
                4'd0: d[15] = ($urandom % 16) == 0;
                4'd1: d = 32'($urandom % 4);
                4'd4, 4'd5, 4'd6: d = (($urandom % 2) == 0) ? 32'($urandom % 24) : d;
                default: ;
            endcase
            step(we, idx, d, 1'($urandom % 2), 1'(($urandom % 8) == 0), req_of(idx));
        end

        // R12 hardware reset mid-run
        bus_we = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        expect_rd(RI_CTRL, 32'h0, "R12");
        expect_rd(4'd6, 32'h0000_0FFF, "R12");
        expect_rd(RI_CNT, 32'h0, "R12");
        expect_rd(RI_IEN, 32'h0, "R12");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule